// File: doc/BRIEF.md
# Segmented Current-DAC Code Linearity Corrector

This block turns a requested 14-bit ideal code for one of six current-output DAC channels into a corrected code. The coarse section of each DAC is built from three sub-DACs, and their bit weights do not match. Per-channel correction factors, measured when the part is tested, are kept in a halfword memory. The block looks up three factors, one for each sub-DAC field of the code, adds them together, and applies the sum to the code once a fixed worst-case margin has been taken off.

A request carries a channel number and an ideal code. The block issues three reads, one per cycle, to a synchronous correction memory. The result is returned on a valid/ready handshake in two forms: the saturated 14-bit code and the packed word for the DAC data register. A channel number with no matching DAC is refused at once and never reaches the memory.

The correction set takes up 312 halfwords, starting at halfword address `BASE_ADDR`. It is split into three channel-major tables placed back to back. The first has 32 entries per channel, the second 4, and the third 16.

Top module: `dac_lin_corr`

## Requirements
- R1: After reset, req_ready_o is 1, res_valid_o is 0 and mem_req_o is 0.
- R2: The adjusted code is the ideal code minus 0x20 when the ideal code is greater than 0x20. Otherwise it is the ideal code unchanged.
- R3: After an accepted request on channel c (0..5), mem_req_o is high for exactly three consecutive cycles, starting one cycle after the accept edge. The halfword addresses are BASE_ADDR+32c+adj[13:9], then BASE_ADDR+192+4c+adj[8:7], then BASE_ADDR+216+16c+adj[6:3].
- R4: The memory answers one cycle after each read, so the data for the read issued in cycle n is taken in cycle n+1.
- R5: Each entry is a signed 16-bit two's-complement value. The three entries are summed, and the sum is added to the adjusted code.
- R6: The corrected code saturates to the range 0 to 0x3FFF.
- R7: res_dat_o holds corrected code bits [13:3] at bits [27:17] and code bits [2:0] at bits [14:12]. All other bits are 0.
- R8: A request on channel 6 or 7 produces no memory read. One cycle after the accept edge, it returns res_err_o=1, res_code_o=0 and res_dat_o=0.
- R9: A valid channel's result becomes valid four cycles after the accept edge.
- R10: req_ready_o stays low from the accept edge until the edge that accepts the result. Requests offered during that time are ignored. The result stays stable while res_ready_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_ch_i | input | 3 | DAC channel number |
| req_code_i | input | 14 | Ideal code |
| mem_req_o | output | 1 | Correction memory read strobe |
| mem_addr_o | output | ADDR_W | Halfword read address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the strobe |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted |
| res_code_o | output | 14 | Corrected, saturated code |
| res_dat_o | output | 32 | Packed DAC data-register word |
| res_err_o | output | 1 | Channel number refused |

## Verification
Two things happen in the same cycle inside the block. A new read address is issued while the data of the previous read is being collected. The memory model returns a different value for every address, so data taken one cycle early or late shows up as a wrong code. The second overlap is at the handshake: a result can be accepted while a fresh request is already waiting. The bench keeps a different request pending for the whole busy period and checks two things: the returned result belongs to the first request, and req_ready_o rises only after the result has been taken.

// File: rtl/dac_lin_pkg.sv
package dac_lin_pkg;
  localparam int NUM_CH   = 6;
  localparam int CODE_W   = 14;
  localparam int ENT_W    = 16;
  localparam int T0_N     = 32;
  localparam int T1_N     = 4;
  localparam int T2_N     = 16;
  localparam int T1_OFF   = NUM_CH * T0_N;
  localparam int T2_OFF   = T1_OFF + NUM_CH * T1_N;
  localparam int TBL_HW   = T2_OFF + NUM_CH * T2_N;
  localparam int SUM_W    = ENT_W + 2;
  localparam int TOT_W    = SUM_W + 2;
  localparam int WC_OFS   = 32;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_FIN, ST_RESP
  } st_e;
endpackage

// File: rtl/dac_lin_addr.sv
module dac_lin_addr
  import dac_lin_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 16'h04C0
) (
  input  logic [2:0]        ch_i,
  input  logic [CODE_W-1:0] adj_i,
  input  logic [1:0]        sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ch_w;
  logic [ADDR_W-1:0] off;

  assign ch_w = ADDR_W'(ch_i);

  always_comb begin
    unique case (sel_i)
      2'd0:    off = (ch_w << 5) + ADDR_W'(adj_i[13:9]);
      2'd1:    off = ADDR_W'(T1_OFF) + (ch_w << 2) + ADDR_W'(adj_i[8:7]);
      default: off = ADDR_W'(T2_OFF) + (ch_w << 4) + ADDR_W'(adj_i[6:3]);
    endcase
  end

  assign addr_o = ADDR_W'(BASE_ADDR) + off;
endmodule

// File: rtl/dac_lin_sat.sv
module dac_lin_sat
  import dac_lin_pkg::*;
(
  input  logic [CODE_W-1:0]       adj_i,
  input  logic signed [SUM_W-1:0] corr_i,
  output logic [CODE_W-1:0]       code_o
);
  logic signed [TOT_W-1:0] total;

  assign total = $signed({{(TOT_W-CODE_W){1'b0}}, adj_i}) + TOT_W'(corr_i);

  always_comb begin
    if (total < 0)                    code_o = '0;
    else if (total > TOT_W'(CODE_MAX)) code_o = CODE_W'(CODE_MAX);
    else                              code_o = total[CODE_W-1:0];
  end
endmodule

// File: rtl/dac_lin_corr.sv
module dac_lin_corr
  import dac_lin_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 16'h04C0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_ch_i,
  input  logic [13:0]       req_code_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [13:0]       res_code_o,
  output logic [31:0]       res_dat_o,
  output logic              res_err_o
);
  st_e                     state;
  logic [2:0]              ch_q;
  logic [CODE_W-1:0]       adj_q, adj_d, code_q, sat_code;
  logic signed [SUM_W-1:0] acc_q, acc_sum, ent;
  logic                    err_q, accept, bad_ch;
  logic [1:0]              sel;

  assign req_ready_o = (state == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign bad_ch      = (int'(req_ch_i) >= NUM_CH);
  assign adj_d       = (int'(req_code_i) > WC_OFS) ? req_code_i - CODE_W'(WC_OFS) : req_code_i;

  always_comb begin
    unique case (state)
      ST_RD1:  sel = 2'd1;
      ST_RD2:  sel = 2'd2;
      default: sel = 2'd0;
    endcase
  end

  assign mem_req_o = (state == ST_RD0) || (state == ST_RD1) || (state == ST_RD2);

  dac_lin_addr #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_addr (
    .ch_i  (ch_q),
    .adj_i (adj_q),
    .sel_i (sel),
    .addr_o(mem_addr_o)
  );

  assign ent     = SUM_W'($signed(mem_rdata_i));
  assign acc_sum = acc_q + ent;

  dac_lin_sat u_sat (
    .adj_i (adj_q),
    .corr_i(acc_sum),
    .code_o(sat_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      ch_q   <= '0;
      adj_q  <= '0;
      acc_q  <= '0;
      code_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          ch_q  <= req_ch_i;
          adj_q <= adj_d;
          acc_q <= '0;
          if (bad_ch) begin
            err_q  <= 1'b1;
            code_q <= '0;
            state  <= ST_RESP;
          end else begin
            err_q <= 1'b0;
            state <= ST_RD0;
          end
        end
        ST_RD0: state <= ST_RD1;
        ST_RD1: begin acc_q <= acc_sum; state <= ST_RD2; end
        ST_RD2: begin acc_q <= acc_sum; state <= ST_FIN; end
        ST_FIN: begin code_q <= sat_code; state <= ST_RESP; end
        ST_RESP: if (res_ready_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_valid_o = (state == ST_RESP);
  assign res_err_o   = err_q;
  assign res_code_o  = code_q;
  assign res_dat_o   = {4'b0, code_q[13:3], 2'b0, code_q[2:0], 12'b0};

  a_r3_addr_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (int'(mem_addr_o - ADDR_W'(BASE_ADDR)) < TBL_HW));
  a_r3_no_read_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !res_valid_o && !req_ready_o);
  a_r8_bad_ch_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_ch_i >= 3'(NUM_CH)) |=> res_valid_o && res_err_o && !mem_req_o);
  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r10_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> res_valid_o && $stable(res_code_o) && $stable(res_dat_o) && $stable(res_err_o));
  a_r6_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_dat_o[31:28] == 4'b0) && (res_dat_o[16:15] == 2'b0));
endmodule

// File: tb/dac_lin_corr_tb.sv
module dac_lin_corr_tb;
  localparam int BASE = 16'h04C0;
  localparam int NHW  = 312;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, res_ready = 0;
  logic [2:0] req_ch = 0;
  logic [13:0] req_code = 0;
  logic mem_req, req_ready, res_valid, res_err;
  logic [15:0] mem_addr, mem_rdata;
  logic [13:0] res_code;
  logic [31:0] res_dat;

  logic [15:0] mem [0:NHW-1];
  int n_chk = 0, n_fail = 0;
  int log_n;
  int log_a [0:7];
  int lat;
  logic [13:0] g_code; logic [31:0] g_dat; logic g_err;

  always #5 clk = ~clk;

  dac_lin_corr #(.ADDR_W(16), .BASE_ADDR(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ch_i(req_ch), .req_code_i(req_code), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_code_o(res_code), .res_dat_o(res_dat), .res_err_o(res_err)
  );

  always @(posedge clk) begin
    int idx;
    idx = int'(mem_addr) - BASE;
    if (mem_req) mem_rdata <= (idx >= 0 && idx < NHW) ? mem[idx] : 16'hDEAD;
  end

  always @(negedge clk) if (mem_req) begin
    if (log_n < 8) log_a[log_n] = int'(mem_addr);
    log_n = log_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic fill_pattern();
    for (int i = 0; i < NHW; i++) begin
      int v;
      v = (i * 37) % 61 - 30;
      mem[i] = v[15:0];
    end
  endtask

  task automatic fill_const(input logic [15:0] v);
    for (int i = 0; i < NHW; i++) mem[i] = v;
  endtask

  function automatic int adj_of(input int code);
    return (code > 32) ? code - 32 : code;
  endfunction

  function automatic int exp_code(input int ch, input int code);
    int a, s, t;
    a = adj_of(code);
    s = int'($signed(mem[ch*32 + ((a >> 9) & 31)]))
      + int'($signed(mem[192 + ch*4 + ((a >> 7) & 3)]))
      + int'($signed(mem[216 + ch*16 + ((a >> 3) & 15)]));
    t = a + s;
    if (t < 0) t = 0;
    if (t > 16383) t = 16383;
    return t;
  endfunction

  task automatic run_req(input int ch, input int code, input int hold, input bit intf);
    @(negedge clk);
    req_valid = 1; req_ch = 3'(ch); req_code = 14'(code); log_n = 0;
    @(negedge clk);
    if (intf) begin req_ch = 3'(ch ^ 1); req_code = 14'(code ^ 14'h1555); end
    else req_valid = 0;
    lat = 1;
    while (!res_valid && lat < 20) begin @(negedge clk); lat++; end
    g_code = res_code; g_dat = res_dat; g_err = res_err;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(res_valid && res_code == g_code && res_dat == g_dat, "R10 hold", int'(res_code), int'(g_code));
      chk(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
    end
    res_ready = 1; req_valid = 0;
    @(negedge clk);
    res_ready = 0;
    chk(req_ready && !res_valid, "R10 ready back after accept", int'(req_ready), 1);
  endtask

  task automatic check_valid(input int ch, input int code, input string tag);
    int e, a;
    e = exp_code(ch, code);
    a = adj_of(code);
    chk(!g_err && g_code == 14'(e), {tag, " R5 code"}, int'(g_code), e);
    chk(g_dat == {4'b0, 11'(e >> 3), 2'b0, 3'(e), 12'b0}, {tag, " R7 word"}, int'(g_dat), e);
    chk(lat == 5, {tag, " R9 latency"}, lat, 5);
    chk(log_n == 3, {tag, " R3 read count"}, log_n, 3);
    chk(log_a[0] == BASE + ch*32 + ((a >> 9) & 31), {tag, " R3 addr0"}, log_a[0], BASE + ch*32 + ((a >> 9) & 31));
    chk(log_a[1] == BASE + 192 + ch*4 + ((a >> 7) & 3), {tag, " R3 addr1"}, log_a[1], BASE + 192 + ch*4 + ((a >> 7) & 3));
    chk(log_a[2] == BASE + 216 + ch*16 + ((a >> 3) & 15), {tag, " R3 addr2"}, log_a[2], BASE + 216 + ch*16 + ((a >> 3) & 15));
  endtask

  task automatic t_reset();
    chk(req_ready && !res_valid && !mem_req, "R1 reset state", {29'b0, req_ready, res_valid, mem_req}, 4);
  endtask

  task automatic t_basic();
    fill_pattern();
    run_req(2, 14'h2815, 0, 0); check_valid(2, 14'h2815, "basic R4");
    run_req(0, 14'h3FFF, 0, 0); check_valid(0, 14'h3FFF, "top");
    run_req(5, 14'h1A5C, 0, 0); check_valid(5, 14'h1A5C, "ch5");
    run_req(3, 14'h0BE8, 0, 0); check_valid(3, 14'h0BE8, "ch3");
  endtask

  task automatic t_offset_edge();
    fill_const(16'h0000);
    run_req(1, 14'h0020, 0, 0);
    chk(g_code == 14'h0020, "R2 code 0x20 unchanged", int'(g_code), 32);
    run_req(1, 14'h0021, 0, 0);
    chk(g_code == 14'h0001, "R2 code 0x21 minus offset", int'(g_code), 1);
    run_req(1, 14'h0000, 0, 0);
    chk(g_code == 14'h0000, "R2 code 0", int'(g_code), 0);
    fill_pattern();
    run_req(4, 14'h0018, 0, 0); check_valid(4, 14'h0018, "R2 small");
  endtask

  task automatic t_saturate();
    fill_const(16'h8000);
    run_req(1, 14'h0100, 0, 0);
    chk(g_code == 0 && g_dat == 0, "R6 low clamp", int'(g_code), 0);
    fill_const(16'h7FFF);
    run_req(1, 14'h3000, 0, 0);
    chk(g_code == 14'h3FFF, "R6 high clamp", int'(g_code), 16383);
    fill_const(16'hFFFF);
    run_req(0, 14'h0023, 0, 0);
    chk(g_code == 14'h0000, "R6 signed sum to zero", int'(g_code), 0);
    fill_pattern();
  endtask

  task automatic t_bad_ch();
    for (int c = 6; c < 8; c++) begin
      run_req(c, 14'h1234, 0, 0);
      chk(g_err && g_code == 0 && g_dat == 0, "R8 error result", int'(g_code), 0);
      chk(log_n == 0, "R8 no memory read", log_n, 0);
      chk(lat == 1, "R8 latency", lat, 1);
    end
  endtask

  task automatic t_busy();
    fill_pattern();
    run_req(3, 14'h2AB0, 4, 1);
    check_valid(3, 14'h2AB0, "R10 request ignored while busy");
    run_req(0, 14'h0400, 2, 0);
    check_valid(0, 14'h0400, "R10 after backpressure");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    fill_pattern();
    log_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_offset_edge();
    t_saturate();
    t_bad_ch();
    t_busy();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule